// File: doc/BRIEF.md
# USB Default Control Endpoint Status/Control Register

This block is the control and status register that firmware uses to run the default control endpoint of a USB device controller. It sits on an indirect register bus. Firmware reads the endpoint state through it and writes commands to it. The packet engine sends in single-cycle event pulses: a data packet has arrived, an IN packet has gone out, a STALL handshake has gone out, a SETUP or OUT packet has overwritten a loaded IN packet, a control transfer ended early, and the status stage completed.

Each bit has its own owner for setting and for clearing. Some bits are set by hardware and released by firmware. Some are set by firmware and released by hardware. Two bits are pure write strobes: each clears a different status bit and always reads back as zero. Three bits (stall request, IN ready and last-data) also drive the packet engine as levels. A one-cycle interrupt pulse follows every event that needs firmware attention.

Top module: `usb_ep0_csr`

## Requirements
- R1: After reset every register bit is 0, the three control outputs are 0 and `irqPulse` is 0.
- R2: With `addr` equal to REG_ADDR (default 0x11), `rdData` shows stall request at bit 5, early-end at bit 4, last-data at bit 3, stall-sent at bit 2, IN ready at bit 1 and OUT ready at bit 0, while bits 7:6 read 0. At any other address `rdData` is 0, and a write there changes nothing.
- R3: OUT ready (bit 0) is set by `evRxPkt`. Only a write with bit 6 = 1 clears it. Writing bit 0 directly has no effect.
- R4: Early-end (bit 4) is set by `evEarlyEnd` only while last-data is 0. A write with bit 7 = 1 clears it.
- R5: A write with bit 5 = 1 sets the stall request, and a write with bit 5 = 0 leaves it unchanged. `evStallSent` clears it. The bit drives `stallReqOut`.
- R6: Stall-sent (bit 2) is set by `evStallSent`. A write with bit 2 = 0 clears it, and a write with bit 2 = 1 has no effect.
- R7: A write with bit 1 = 1 sets IN ready (`txReadyOut`), and a write with bit 1 = 0 has no effect. `evTxDone` or `evOverwrite` clears it.
- R8: A write with bit 3 = 1 sets last-data (`lastDataOut`). `evStatusDone` clears it.
- R9: When a hardware set of OUT ready, early-end or stall-sent falls in the same cycle as a firmware clear of that bit, the bit ends up set.
- R10: `irqPulse` is high for exactly the one cycle after any of these events: `evRxPkt`; a hardware clear of IN ready while it was set; a qualifying early-end set; `evStallSent`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 8 | Indirect register address for reads and writes |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational on `addr` |
| evRxPkt | input | 1 | Data packet received |
| evTxDone | input | 1 | IN packet transmitted |
| evStallSent | input | 1 | STALL handshake transmitted |
| evOverwrite | input | 1 | SETUP/OUT packet overwrote the IN packet |
| evEarlyEnd | input | 1 | Control transfer ended early |
| evStatusDone | input | 1 | Status stage completed |
| stallReqOut | output | 1 | Stall request level to the packet engine |
| txReadyOut | output | 1 | IN packet ready level |
| lastDataOut | output | 1 | Last data packet marker level |
| irqPulse | output | 1 | One-cycle interrupt request |

## Verification
The bench targets the cross-wired clears. If the strobe-to-target mapping were swapped, writing bit 6 would clear early-end and leave OUT ready stuck. If the stall-sent polarity were inverted, firmware could set that bit itself, or a routine write of zero would fail to clear it. The bench also drives a hardware event and a firmware clear of the same bit in the same cycle: a design where the clear wins would lose an arrived packet or a stall notice. Finally, it checks that an early end while last-data is set raises neither the bit nor an interrupt, and that a transmit-done event while IN ready is already clear gives no spurious interrupt.

// File: rtl/ep0_csr_pkg.sv
package ep0_csr_pkg;
  localparam int BIT_OUTRDY   = 0;
  localparam int BIT_INRDY    = 1;
  localparam int BIT_STSENT   = 2;
  localparam int BIT_LASTDATA = 3;
  localparam int BIT_EARLYEND = 4;
  localparam int BIT_STALLREQ = 5;
  localparam int BIT_CLRRX    = 6;
  localparam int BIT_CLREARLY = 7;

  typedef struct packed {
    logic clrEarly;
    logic clrRx;
    logic setStall;
    logic setLast;
    logic clrStallSent;
    logic setTx;
  } ep0Strobe_t;

  typedef struct packed {
    logic rxPkt;
    logic txDone;
    logic stallSent;
    logic overwrite;
    logic earlyEnd;
    logic statusDone;
  } ep0Event_t;
endpackage

// File: rtl/ep0_csr_ctrl.sv
module ep0_csr_ctrl
  import ep0_csr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h11
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic              regHit,
  output ep0Strobe_t        strb
);
  logic wrHit;

  assign regHit = (addr == REG_ADDR);
  assign wrHit  = wrEn && regHit;

  always_comb begin
    strb              = '0;
    strb.clrEarly     = wrHit &&  wrData[BIT_CLREARLY];
    strb.clrRx        = wrHit &&  wrData[BIT_CLRRX];
    strb.setStall     = wrHit &&  wrData[BIT_STALLREQ];
    strb.setLast      = wrHit &&  wrData[BIT_LASTDATA];
    strb.clrStallSent = wrHit && !wrData[BIT_STSENT];
    strb.setTx        = wrHit &&  wrData[BIT_INRDY];
  end
endmodule

// File: rtl/ep0_csr_dp.sv
module ep0_csr_dp
  import ep0_csr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ep0Strobe_t        strb,
  input  ep0Event_t         ev,
  output logic [DATA_W-1:0] regVal,
  output logic              irq
);
  logic outRdy, inRdy, stSent, lastData, earlyEnd, stallReq;
  logic earlySet, txHwClr;

  assign earlySet = ev.earlyEnd && !lastData;
  assign txHwClr  = ev.txDone || ev.overwrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outRdy   <= 1'b0;
      inRdy    <= 1'b0;
      stSent   <= 1'b0;
      lastData <= 1'b0;
      earlyEnd <= 1'b0;
      stallReq <= 1'b0;
      irq      <= 1'b0;
    end else begin
      outRdy   <= ev.rxPkt     || (outRdy   && !strb.clrRx);
      earlyEnd <= earlySet     || (earlyEnd && !strb.clrEarly);
      stSent   <= ev.stallSent || (stSent   && !strb.clrStallSent);
      stallReq <= strb.setStall || (stallReq && !ev.stallSent);
      inRdy    <= strb.setTx    || (inRdy    && !txHwClr);
      lastData <= strb.setLast  || (lastData && !ev.statusDone);
      irq      <= ev.rxPkt || (inRdy && txHwClr) || earlySet || ev.stallSent;
    end
  end

  always_comb begin
    regVal               = '0;
    regVal[BIT_OUTRDY]   = outRdy;
    regVal[BIT_INRDY]    = inRdy;
    regVal[BIT_STSENT]   = stSent;
    regVal[BIT_LASTDATA] = lastData;
    regVal[BIT_EARLYEND] = earlyEnd;
    regVal[BIT_STALLREQ] = stallReq;
  end

  // R3
  rx_only_sw_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outRdy) |-> $past(strb.clrRx));
  // R9
  rx_hw_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    ev.rxPkt |=> outRdy);
  // R9
  stall_sent_hw_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    ev.stallSent |=> stSent);
  // R5
  stall_req_hw_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stallReq) |-> $past(ev.stallSent));
  // R10
  tx_clear_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inRdy && txHwClr) |=> irq);
  // R4
  early_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ev.earlyEnd && lastData && !earlyEnd) |=> !earlyEnd);
endmodule

// File: rtl/usb_ep0_csr.sv
module usb_ep0_csr
  import ep0_csr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              evRxPkt,
  input  logic              evTxDone,
  input  logic              evStallSent,
  input  logic              evOverwrite,
  input  logic              evEarlyEnd,
  input  logic              evStatusDone,
  output logic              stallReqOut,
  output logic              txReadyOut,
  output logic              lastDataOut,
  output logic              irqPulse
);
  ep0Strobe_t        strb;
  ep0Event_t         ev;
  logic              regHit;
  logic [DATA_W-1:0] regVal;

  assign ev.rxPkt      = evRxPkt;
  assign ev.txDone     = evTxDone;
  assign ev.stallSent  = evStallSent;
  assign ev.overwrite  = evOverwrite;
  assign ev.earlyEnd   = evEarlyEnd;
  assign ev.statusDone = evStatusDone;

  ep0_csr_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_ctrl (
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .regHit(regHit), .strb(strb)
  );

  ep0_csr_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ev(ev), .regVal(regVal), .irq(irqPulse)
  );

  assign rdData      = regHit ? regVal : '0;
  assign stallReqOut = regVal[BIT_STALLREQ];
  assign txReadyOut  = regVal[BIT_INRDY];
  assign lastDataOut = regVal[BIT_LASTDATA];
endmodule

// File: tb/usb_ep0_csr_bench.sv
module usb_ep0_csr_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] addr = 8'h11;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       evRxPkt = 0, evTxDone = 0, evStallSent = 0;
  logic       evOverwrite = 0, evEarlyEnd = 0, evStatusDone = 0;
  logic       stallReqOut, txReadyOut, lastDataOut, irqPulse;
  int         nRun = 0, nFail = 0;
  bit         done = 0;

  // event vector order: {statusDone, earlyEnd, overwrite, stallSent, txDone, rxPkt}
  localparam logic [5:0] E_RX = 6'h01, E_TXD = 6'h02, E_STS = 6'h04,
                         E_OVW = 6'h08, E_EARLY = 6'h10, E_STAT = 6'h20;

  always #4 clk = ~clk;

  usb_ep0_csr u_usb_ep0_csr (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .evRxPkt(evRxPkt), .evTxDone(evTxDone), .evStallSent(evStallSent),
    .evOverwrite(evOverwrite), .evEarlyEnd(evEarlyEnd), .evStatusDone(evStatusDone),
    .stallReqOut(stallReqOut), .txReadyOut(txReadyOut), .lastDataOut(lastDataOut),
    .irqPulse(irqPulse)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // one cycle: optional write plus events, applied at negedge, done by next negedge
  task automatic step(input logic w, input logic [7:0] d, input logic [5:0] e);
    wrEn = w; wrData = d; addr = 8'h11;
    {evStatusDone, evEarlyEnd, evOverwrite, evStallSent, evTxDone, evRxPkt} = e;
    @(negedge clk);
    wrEn = 0; wrData = 0;
    {evStatusDone, evEarlyEnd, evOverwrite, evStallSent, evTxDone, evRxPkt} = 6'h0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic testReset();
    chk("R1 reg", rdData, 8'h00);
    chk("R1 outs", {4'h0, stallReqOut, txReadyOut, lastDataOut, irqPulse}, 8'h00);
  endtask

  task automatic testRx();
    step(0, 0, E_RX);
    chk("R3 rx set", rdData, 8'h01);
    chk("R10 rx irq", {7'h0, irqPulse}, 8'h01);
    idle();
    chk("R10 irq one cycle", {7'h0, irqPulse}, 8'h00);
    step(1, 8'h00, 0);
    chk("R3 write0 no effect", rdData, 8'h01);
    step(1, 8'h01, 0);
    chk("R3 read-only", rdData, 8'h01);
    step(1, 8'h40, 0);
    chk("R3 R2 strobe clears, reads 0", rdData, 8'h00);
  endtask

  task automatic testEarly();
    step(0, 0, E_EARLY);
    chk("R4 early set", rdData, 8'h10);
    chk("R10 early irq", {7'h0, irqPulse}, 8'h01);
    step(1, 8'h40, 0);
    chk("R4 wrong strobe keeps", rdData, 8'h10);
    step(1, 8'h80, 0);
    chk("R4 strobe clears", rdData, 8'h00);
    step(1, 8'h08, 0);
    chk("R8 last set", {rdData[7:1], lastDataOut}, 8'h09);
    step(0, 0, E_EARLY);
    chk("R4 blocked by last", rdData, 8'h08);
    chk("R10 no irq when blocked", {7'h0, irqPulse}, 8'h00);
    step(0, 0, E_STAT);
    chk("R8 status done clears", {rdData[7:1], lastDataOut}, 8'h00);
  endtask

  task automatic testStall();
    step(1, 8'h20, 0);
    chk("R5 stall set", {rdData[7:1], stallReqOut}, 8'h21);
    step(1, 8'h00, 0);
    chk("R5 write0 no effect", rdData, 8'h20);
    step(0, 0, E_STS);
    chk("R5 R6 stall sent", rdData, 8'h04);
    chk("R10 stall irq", {7'h0, irqPulse}, 8'h01);
    step(1, 8'h04, 0);
    chk("R6 write1 no effect", rdData, 8'h04);
    step(1, 8'h00, 0);
    chk("R6 write0 clears", rdData, 8'h00);
  endtask

  task automatic testTx();
    step(1, 8'h02, 0);
    chk("R7 tx set", {rdData[7:1], txReadyOut}, 8'h03);
    chk("R10 no irq on sw set", {7'h0, irqPulse}, 8'h00);
    step(1, 8'h00, 0);
    chk("R7 write0 no effect", rdData, 8'h02);
    step(0, 0, E_TXD);
    chk("R7 tx done clears", rdData, 8'h00);
    chk("R10 tx done irq", {7'h0, irqPulse}, 8'h01);
    step(1, 8'h02, 0);
    step(0, 0, E_OVW);
    chk("R7 overwrite clears", rdData, 8'h00);
    chk("R10 overwrite irq", {7'h0, irqPulse}, 8'h01);
    step(0, 0, E_TXD);
    chk("R10 no irq when idle", {7'h0, irqPulse}, 8'h00);
  endtask

  task automatic testConflict();
    step(0, 0, E_RX);
    step(1, 8'h40, E_RX);
    chk("R9 rx set wins", rdData, 8'h01);
    step(0, 0, E_EARLY);
    step(1, 8'h80, E_EARLY);
    chk("R9 early set wins", rdData, 8'h11);
    step(1, 8'hC0, 0);
    step(0, 0, E_STS);
    step(1, 8'h00, E_STS);
    chk("R9 stall sent wins", rdData, 8'h04);
    step(1, 8'h00, 0);
    chk("R9 cleanup", rdData, 8'h00);
  endtask

  task automatic testAddr();
    wrEn = 1; addr = 8'h12; wrData = 8'h2A;
    @(negedge clk);
    wrEn = 0; addr = 8'h11;
    #1 chk("R2 foreign write ignored", rdData, 8'h00);
    step(0, 0, E_RX);
    addr = 8'h10;
    #1 chk("R2 foreign read zero", rdData, 8'h00);
    addr = 8'h11;
    #1 chk("R2 own read", rdData, 8'h01);
    step(1, 8'h40, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testRx();
    testEarly();
    testStall();
    testTx();
    testConflict();
    testAddr();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule